// File: doc/BRIEF.md
# Shifting-Cell Push-Down Stack

This block is a last-in-first-out store built from a chain of word registers in which the data itself moves, rather than a pointer moving over a RAM. Cell 0 always holds the most recent word. A push loads the new word into cell 0 and moves every stored word one cell deeper. A pop removes the word in cell 0 and moves every remaining word one cell toward the top. A zero word enters at the bottom of the chain during a pop.

The word in cell 0 is always visible on `top_data`, so it can be read without removing it. A separate index port reads any cell combinationally, and this read leaves the stack unchanged. An occupancy counter drives the `empty` and `full` outputs. A push offered to a full stack is refused and reported by an overflow pulse. A pop requested on an empty stack is refused and reported by an underflow pulse.

Words enter through a valid/ready stream. A word transfers on a clock edge where `push_valid` and `push_ready` are both high. `push_ready` is low while the stack is full and in any cycle where `pop_req` is high, so a producer must hold its word until `push_ready` returns. Pop is a plain strobe and takes priority over a push offered in the same cycle.

Top module: `shift_stack`

## Requirements
- R1: A push transfer places `push_data` in cell 0 and moves each stored word from cell i to cell i+1; `count` rises by one.
- R2: A pop with `count` > 0 removes cell 0 and moves each word from cell i+1 to cell i; `count` falls by one. The word popped is the one on `top_data` in the cycle of the request.
- R3: `top_data` always shows cell 0, and no cell changes in a cycle with no push transfer and no accepted pop.
- R4: `rd_data` combinationally shows cell `rd_idx` (0 = top), and reading it has no effect on any cell or on `count`.
- R5: `count` lies between 0 and DEPTH; `empty` is high exactly when `count` is 0; `full` is high exactly when `count` equals DEPTH.
- R6: `push_ready` is high only when the stack is not full and `pop_req` is low. A `push_valid` while full and with no pop gives a one-cycle `overflow` pulse in the next cycle and leaves every cell and `count` unchanged.
- R7: A `pop_req` while empty gives a one-cycle `underflow` pulse in the next cycle and leaves `count` and every cell unchanged.
- R8: After reset every cell reads zero and `count` is 0. Every cell at an index of `count` or above reads zero, including cells emptied by a pop.
- R9: When `pop_req` and `push_valid` are both high, only the pop takes effect and the offered word is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers `push_data` |
| push_ready | output | 1 | Stack will accept the offered word this cycle |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop strobe for one word |
| top_data | output | DATA_W | Word in cell 0 (peek) |
| rd_idx | input | IDX_W | Cell selected for the indexed read |
| rd_data | output | DATA_W | Word in the selected cell |
| count | output | CNT_W | Number of stored words |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| overflow | output | 1 | Pulse: a push was refused because the stack was full |
| underflow | output | 1 | Pulse: a pop was refused because the stack was empty |

## Verification
A wrong shift direction or a missed move shows on `top_data` right after the next pop. It shows on `rd_data` at once, because every cell is visible through the index port. A counter that drifts from the cell contents shows on `empty`, `full` or `push_ready` within one cycle. It also shows as a nonzero word read above `count`. The bench therefore compares all outputs with a reference model in every cycle and sweeps `rd_idx` at random. An error in the cell chain or the counter is then reported in the cycle it occurs and does not surface many operations later.

// File: rtl/shstk_pkg.sv
package shstk_pkg;
  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_LOAD = 2'd1,
    SH_LIFT = 2'd2
  } shift_op_e;
endpackage

// File: rtl/shstk_ctrl.sv
module shstk_ctrl
  import shstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             pop_req,
  output logic             push_ready,
  output shift_op_e        op,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             overflow,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

  logic push_fire, pop_fire;

  assign empty      = (count == '0);
  assign full       = (count == LIMIT);
  assign push_ready = !full && !pop_req;
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_req && !empty;

  always_comb begin
    if (push_fire)     op = SH_LOAD;
    else if (pop_fire) op = SH_LIFT;
    else               op = SH_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= push_valid && full && !pop_req;
      underflow <= pop_req && empty;
      case (op)
        SH_LOAD: count <= count + 1'b1;
        SH_LIFT: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT); // R5
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ready); // R6
  AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop_req) |=> (overflow && $stable(count))); // R6
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> (underflow && count == '0)); // R7
  AST_POP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && push_valid && !empty) |=> (count == $past(count) - 1'b1)); // R9
endmodule

// File: rtl/shstk_cell.sv
module shstk_cell
  import shstk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  shift_op_e         op,
  input  logic [DATA_W-1:0] from_above,
  input  logic [DATA_W-1:0] from_below,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      case (op)
        SH_LOAD: q <= from_above;
        SH_LIFT: q <= from_below;
        default: q <= q;
      endcase
    end
  end

  AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SH_HOLD) |=> $stable(q)); // R3
endmodule

// File: rtl/shstk_rdmux.sv
module shstk_rdmux #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] cells,
  input  logic [IDX_W-1:0]             idx,
  output logic [DATA_W-1:0]            data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) data = cells[i];
    end
  end
endmodule

// File: rtl/shift_stack.sv
module shift_stack
  import shstk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] top_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full,
  output logic              overflow,
  output logic              underflow
);
  shift_op_e                   op;
  logic [DEPTH-1:0][DATA_W-1:0] cells;

  shstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .push_ready (push_ready),
    .op         (op),
    .count      (count),
    .empty      (empty),
    .full       (full),
    .overflow   (overflow),
    .underflow  (underflow)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] above, below;
    if (g == 0) begin : g_top
      assign above = push_data;
    end else begin : g_mid
      assign above = cells[g-1];
    end
    if (g == DEPTH - 1) begin : g_bot
      assign below = '0;
    end else begin : g_up
      assign below = cells[g+1];
    end
    shstk_cell #(.DATA_W(DATA_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .from_above (above),
      .from_below (below),
      .q          (cells[g])
    );
  end

  shstk_rdmux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rdmux (
    .cells (cells),
    .idx   (rd_idx),
    .data  (rd_data)
  );

  assign top_data = cells[0];

  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (top_data == $past(push_data))); // R1
  AST_PUSH_DEEPER: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (cells[DEPTH-1] == $past(cells[DEPTH-2]))); // R1
  AST_POP_LIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty) |=> (top_data == $past(cells[1]))); // R2
  AST_VACATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty) |=> (cells[DEPTH-1] == '0)); // R8
  AST_EMPTY_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (top_data == '0)); // R8
endmodule

// File: tb/test_shift_stack.sv
module test_shift_stack;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = 3;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic              push_ready;
  logic [DATA_W-1:0] push_data = '0;
  logic              pop_req = 1'b0;
  logic [DATA_W-1:0] top_data;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  count;
  logic              empty, full, overflow, underflow;

  always #4 clk = ~clk;

  shift_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_shift_stack (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .pop_req(pop_req), .top_data(top_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .count(count), .empty(empty),
    .full(full), .overflow(overflow), .underflow(underflow)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int m_cell [DEPTH];
  int m_cnt  = 0;
  bit exp_ovf = 0;
  bit exp_unf = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_ready(input bit pop);
    return (m_cnt < DEPTH) && !pop;
  endfunction

  task automatic check_outputs();
    chk("R3 top_data", int'(top_data), m_cell[0]);
    chk("R4 rd_data", int'(rd_data), m_cell[rd_idx]);
    chk("R5 count", int'(count), m_cnt);
    chk("R5 empty", int'(empty), int'(m_cnt == 0));
    chk("R5 full", int'(full), int'(m_cnt == DEPTH));
    chk("R6 push_ready", int'(push_ready), int'(m_ready(pop_req)));
    chk("R6 overflow", int'(overflow), int'(exp_ovf));
    chk("R7 underflow", int'(underflow), int'(exp_unf));
  endtask

  task automatic model_edge();
    bit pf, of;
    pf = push_valid && m_ready(pop_req);
    of = pop_req && (m_cnt > 0);
    exp_ovf = push_valid && (m_cnt == DEPTH) && !pop_req;
    exp_unf = pop_req && (m_cnt == 0);
    if (pf) begin
      for (int i = DEPTH - 1; i > 0; i--) m_cell[i] = m_cell[i-1];
      m_cell[0] = int'(push_data);
      m_cnt++;
    end else if (of) begin
      for (int i = 0; i < DEPTH - 1; i++) m_cell[i] = m_cell[i+1];
      m_cell[DEPTH-1] = 0;
      m_cnt--;
    end
  endtask

  task automatic step(input bit pv, input int pd, input bit pr, input int ix);
    @(negedge clk);
    push_valid = pv;
    push_data  = DATA_W'(pd);
    pop_req    = pr;
    rd_idx     = IDX_W'(ix);
    #1;
    check_outputs();
    model_edge();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int i = 0; i < DEPTH; i++) m_cell[i] = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = IDX_W'(i);
      #1;
      chk("R8 reset cell", int'(rd_data), 0);
    end
    chk("R8 reset count", int'(count), 0);
    rst_n = 1'b1;

    // R7: pop on empty
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    // R1: fill to full with distinct words
    for (int i = 0; i < DEPTH; i++) step(1, 16'h1100 + i, 0, i);
    // R6: push on full, twice, then idle
    step(1, 16'hDEAD, 0, 7);
    step(1, 16'hBEEF, 0, 0);
    step(0, 0, 0, 3);
    // R4/R3: sweep indexed read on a stable full stack
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, i);
    // R9: pop with push offered together
    step(1, 16'hCAFE, 1, 1);
    step(1, 16'hCAFE, 1, 6);
    // R2/R8: drain past empty
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 7 - (i % DEPTH));
    step(0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit pv, pr;
      r  = int'($urandom_range(0, 99));
      pv = (r < 50);
      pr = (r >= 40 && r < 75);
      step(pv, int'($urandom_range(0, 65535)), pr, int'($urandom_range(0, DEPTH - 1)));
    end
    step(0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule